// File: doc/BRIEF.md
# Overclock Watchdog with Safe Frequency Fallback

This block guards the 5-bit frequency-select code that a clock generator hands to its synthesizer. Once armed, it counts down whole time units from a programmable count. If the count runs out before the system services it, the block enters an alarm state. In that state it replaces the active frequency code with a programmable safe code. It also routes the frequency source back to the code path, away from the programmed divider path, so that a hung overclocked system returns to a known setting without a full reset.

One time unit is a whole number of clock cycles, set by a parameter. A real part uses about 290 ms per unit. A simulation uses a handful of cycles. The block holds two registers. One is a count register, which resets to 16 units, or about 4.6 s at 290 ms per unit. The other is a control register.

The control register has these fields:
- bit 7: source select, reset 0.
- bit 6: enable, reset 0.
- bit 5: status, written 0 to clear.
- bits 4:0: safe code, reset 0.

A separate service strobe stands for any configuration write elsewhere in the chip and restarts the countdown.

The control logic is a three-state machine:
- `WD_OFF`: disabled. The counter is held at the reload value.
- `WD_RUN`: counting down.
- `WD_TRIP`: alarm.

The transitions between them:
- OFF→RUN: enable written to 1.
- RUN→OFF: enable written to 0.
- RUN→RUN reload: service strobe.
- RUN→TRIP: a unit tick arrives while the counter is 1 or 0.
- TRIP→OFF: enable written to 0.
- TRIP→RUN: a control write with status bit 0 and enable 1.

Top module: `ovc_watchdog`

## Requirements
- R1: After reset `alarm` is 0, `src_sel` is 0, `eff_code` equals `norm_code`, and the count register holds 16. Enabling the watchdog without writing the count raises `alarm` exactly 16 units after the enabling write edge.
- R2: While control bit 6 (enable) is 0, `alarm` stays 0, service strobes have no effect, and `eff_code` follows `norm_code`.
- R3: With no service, a control write that sets bit 6 with count N ≥ 1 makes `alarm` read 0 for the first N·UNIT_CYCLES−1 cycles after that edge. `alarm` reads 1 from edge N·UNIT_CYCLES onward.
- R4: A service strobe while counting restarts the full timeout. `alarm` rises exactly N·UNIT_CYCLES edges after the strobe edge.
- R5: While `alarm` is 1, `eff_code` equals the safe code in control bits 4:0 and `src_sel` is 0.
- R6: The alarm is sticky. Service strobes while `alarm` is 1 leave it at 1.
- R7: A control write with bit 6 = 1 and bit 5 = 0 while in alarm clears `alarm` at that edge and starts a fresh timeout with the current count.
- R8: A control write with bit 6 = 0 clears `alarm` at that edge and returns `eff_code` to `norm_code`.
- R9: A service strobe in the same cycle as the final unit tick wins. No alarm is raised, and a full timeout starts from that edge.
- R10: A count of 0 behaves as a count of 1, so the alarm rises one unit after enabling.
- R11: While `alarm` is 0, `src_sel` equals control bit 7.
- R12: A control write with bit 5 = 1 while in alarm keeps the alarm, and the newly written safe code appears on `eff_code` from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_code | input | CODE_W | Frequency code from the latched pins or register selection |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | CNT_W | New timeout count in units |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | CODE_W+3 | Control data: bit 7 source, bit 6 enable, bit 5 status (0 clears), bits 4:0 safe code |
| svc | input | 1 | Service strobe, one cycle per configuration write |
| eff_code | output | CODE_W | Frequency code in effect |
| src_sel | output | 1 | Source select: 0 uses the code path, 1 uses the divider path |
| alarm | output | 1 | Alarm status, 1 after expiry |

## Verification
The service reload and the expiry decision can both land on the same clock edge: the one on which the last unit tick of a running countdown arrives. The bench arms a short count, counts cycles from the enabling edge, and drives the service strobe so that it is sampled exactly on the edge of the final tick. It judges the outcome by `alarm` staying 0 on that edge and on every edge up to one full timeout later, then rising exactly on the edge a complete timeout after the strobe. A checker property also requires that a serviced running cycle is never followed by an alarm.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

    // Control field positions, derived from the safe-code width
    function automatic int ctl_src_bit(input int code_w);
        return code_w + 2;
    endfunction

    function automatic int ctl_en_bit(input int code_w);
        return code_w + 1;
    endfunction

    function automatic int ctl_stat_bit(input int code_w);
        return code_w;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CODE_W  = 5,
    parameter int CNT_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ctl_wr,
    input  logic [CODE_W+2:0] ctl_wdata,
    output logic [CNT_W-1:0]  limit_q,
    output logic              en_q,
    output logic              src_q,
    output logic [CODE_W-1:0] safe_q,
    output logic              en_next,
    output logic              clr_req
);

    localparam int SRC_B  = ctl_src_bit(CODE_W);
    localparam int EN_B   = ctl_en_bit(CODE_W);
    localparam int STAT_B = ctl_stat_bit(CODE_W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= CNT_W'(CNT_RST);
        end else if (cnt_wr) begin
            limit_q <= cnt_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            src_q  <= 1'b0;
            safe_q <= '0;
        end else if (ctl_wr) begin
            en_q   <= ctl_wdata[EN_B];
            src_q  <= ctl_wdata[SRC_B];
            safe_q <= ctl_wdata[CODE_W-1:0];
        end
    end

    // The state machine acts on the value being written, not the stored one
    always_comb begin
        en_next = ctl_wr ? ctl_wdata[EN_B] : en_q;
        clr_req = ctl_wr && !ctl_wdata[STAT_B];
    end

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int UNIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (UNIT_CYCLES <= 1) begin : g_direct
            assign tick = run && !restart;
        end else begin : g_count
            localparam int PRE_W = $clog2(UNIT_CYCLES);
            localparam logic [PRE_W-1:0] LAST = PRE_W'(UNIT_CYCLES - 1);

            logic [PRE_W-1:0] pre_q;
            logic             at_last;

            assign at_last = (pre_q == LAST);
            assign tick    = run && !restart && at_last;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (!run || restart || at_last) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_next,
    input  logic              clr_req,
    input  logic              svc,
    input  logic              tick,
    input  logic [CNT_W-1:0]  limit,
    input  logic [CODE_W-1:0] norm_code,
    input  logic [CODE_W-1:0] safe_code,
    input  logic              src_pick,
    output logic              running,
    output logic              restart,
    output logic              alarm,
    output logic [CODE_W-1:0] eff_code,
    output logic              src_out
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             load, dec;

    // Next state and counter actions
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        dec  = 1'b0;
        unique case (st_q)
            WD_OFF: begin
                if (en_next) begin
                    st_d = WD_RUN;
                    load = 1'b1;
                end
            end
            WD_RUN: begin
                if (!en_next) begin
                    st_d = WD_OFF;
                end else if (svc) begin
                    load = 1'b1;
                end else if (tick) begin
                    if (cnt_q <= ONE) begin
                        st_d = WD_TRIP;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            WD_TRIP: begin
                if (!en_next) begin
                    st_d = WD_OFF;
                end else if (clr_req) begin
                    st_d = WD_RUN;
                    load = 1'b1;
                end
            end
            default: begin
                st_d = WD_OFF;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WD_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Unit counter: parked at the reload value while off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == WD_OFF || load) begin
            cnt_q <= limit;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Outputs
    always_comb begin
        alarm    = (st_q == WD_TRIP);
        running  = (st_q == WD_RUN);
        restart  = running && svc;
        eff_code = alarm ? safe_code : norm_code;
        src_out  = alarm ? 1'b0 : src_pick;
    end

endmodule

// File: rtl/ovc_watchdog.sv
module ovc_watchdog
    import wdg_pkg::*;
#(
    parameter int UNIT_CYCLES = 1000,
    parameter int CNT_W       = 8,
    parameter int CODE_W      = 5,
    parameter int CNT_RST     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] norm_code,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ctl_wr,
    input  logic [CODE_W+2:0] ctl_wdata,
    input  logic              svc,
    output logic [CODE_W-1:0] eff_code,
    output logic              src_sel,
    output logic              alarm
);

    logic [CNT_W-1:0]  limit_q;
    logic              en_q;
    logic              src_q;
    logic [CODE_W-1:0] safe_q;
    logic              en_next;
    logic              clr_req;
    logic              running;
    logic              restart;
    logic              unit_tick;

    wdg_regs #(
        .CNT_W   (CNT_W),
        .CODE_W  (CODE_W),
        .CNT_RST (CNT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .limit_q   (limit_q),
        .en_q      (en_q),
        .src_q     (src_q),
        .safe_q    (safe_q),
        .en_next   (en_next),
        .clr_req   (clr_req)
    );

    wdg_prescale #(
        .UNIT_CYCLES (UNIT_CYCLES)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (restart),
        .tick    (unit_tick)
    );

    wdg_fsm #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next   (en_next),
        .clr_req   (clr_req),
        .svc       (svc),
        .tick      (unit_tick),
        .limit     (limit_q),
        .norm_code (norm_code),
        .safe_code (safe_q),
        .src_pick  (src_q),
        .running   (running),
        .restart   (restart),
        .alarm     (alarm),
        .eff_code  (eff_code),
        .src_out   (src_sel)
    );

endmodule

// File: rtl/ovc_watchdog_chk.sv
module ovc_watchdog_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alarm,
    input logic              svc,
    input logic              ctl_wr,
    input logic              en_q,
    input logic              tick,
    input logic [CODE_W-1:0] eff_code,
    input logic [CODE_W-1:0] safe_q,
    input logic              src_sel
);

    // R5
    alarm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (eff_code == safe_q));

    // R5
    alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (src_sel == 1'b0));

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !alarm);

    // R3
    trip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(tick));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !ctl_wr) |=> alarm);

    // R9
    svc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && en_q && !alarm && !ctl_wr) |=> !alarm);

endmodule

bind ovc_watchdog ovc_watchdog_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alarm    (alarm),
    .svc      (svc),
    .ctl_wr   (ctl_wr),
    .en_q     (en_q),
    .tick     (unit_tick),
    .eff_code (eff_code),
    .safe_q   (safe_q),
    .src_sel  (src_sel)
);

// File: tb/ovc_watchdog_bench.sv
module ovc_watchdog_bench;

    localparam int U = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] norm_code = 5'h0A;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       svc = 1'b0;
    logic [4:0] eff_code;
    logic       src_sel;
    logic       alarm;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        bit         a;
        logic [4:0] code;
        bit         src;
        string      tag;
    } exp_t;

    exp_t sb[$];

    ovc_watchdog #(.UNIT_CYCLES(U)) u_ovc_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .norm_code (norm_code),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .svc       (svc),
        .eff_code  (eff_code),
        .src_sel   (src_sel),
        .alarm     (alarm)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].at == cyc) begin
                n_run++;
                if (alarm !== sb[i].a || eff_code !== sb[i].code || src_sel !== sb[i].src) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d: alarm=%0d code=%h src=%0d expected alarm=%0d code=%h src=%0d",
                             sb[i].tag, cyc, alarm, eff_code, src_sel, sb[i].a, sb[i].code, sb[i].src);
                end
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic expect_at(input int at, input bit a, input logic [4:0] code,
                             input bit src, input string tag);
        exp_t e;
        e.at = at; e.a = a; e.code = code; e.src = src; e.tag = tag;
        sb.push_back(e);
    endtask

    // All drive tasks start at a falling edge and return one falling edge later
    task automatic put_ctl(input logic [7:0] d, output int mark);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        mark = cyc;
    endtask

    task automatic put_cnt(input logic [7:0] d);
        cnt_wr = 1'b1; cnt_wdata = d;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic pulse_svc(output int mark);
        svc = 1'b1;
        @(negedge clk);
        svc = 1'b0;
        mark = cyc;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int m, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_at(cyc + 1, 0, 5'h0A, 0, "R1 reset");
        @(negedge clk);

        // R1 / R3: default count of 16 units
        put_ctl(8'h63, m);
        expect_at(m, 0, 5'h0A, 0, "R3 armed");
        expect_at(m + 16*U - 1, 0, 5'h0A, 0, "R1 before default expiry");
        expect_at(m + 16*U, 1, 5'h03, 0, "R1 default expiry");
        wait_until(m + 16*U + 2);

        // R6: service ignored in alarm
        pulse_svc(s);
        expect_at(s + 1, 1, 5'h03, 0, "R6 sticky");
        wait_until(s + 3);

        // R12: status written 1 keeps alarm, new safe code shows
        put_ctl(8'h65, m);
        expect_at(m, 1, 5'h05, 0, "R12 keep alarm");
        put_cnt(8'd3);

        // R7: clear restarts with count 3
        put_ctl(8'h45, m);
        expect_at(m, 0, 5'h0A, 0, "R7 cleared");
        expect_at(m + 3*U - 1, 0, 5'h0A, 0, "R7 before re-expiry");
        expect_at(m + 3*U, 1, 5'h05, 0, "R7 re-expiry");
        wait_until(m + 3*U + 2);

        // R8: disable clears alarm
        put_ctl(8'h05, m);
        expect_at(m, 0, 5'h0A, 0, "R8 disable clears");
        pulse_svc(s);
        expect_at(m + 40, 0, 5'h0A, 0, "R2 stays quiet");
        wait_until(m + 41);
        norm_code = 5'h1F;
        expect_at(cyc + 1, 0, 5'h1F, 0, "R2 follows norm code");
        @(negedge clk); @(negedge clk);
        norm_code = 5'h0A;
        @(negedge clk);

        // R11 / R4: source bit and service restart
        put_ctl(8'hC5, m);
        expect_at(m, 0, 5'h0A, 1, "R11 source bit");
        expect_at(m + 3*U, 0, 5'h0A, 1, "R4 no expiry after service");
        wait_until(m + 7);
        pulse_svc(s);
        expect_at(s + 3*U - 1, 0, 5'h0A, 1, "R4 before expiry");
        expect_at(s + 3*U, 1, 5'h05, 0, "R4 expiry / R5 source forced");
        wait_until(s + 3*U + 2);

        // R9: service on the final tick edge
        put_ctl(8'h05, m);
        put_cnt(8'd2);
        put_ctl(8'h45, m);
        wait_until(m + 2*U - 1);
        pulse_svc(s);
        expect_at(s, 0, 5'h0A, 0, "R9 service wins");
        expect_at(s + 2*U - 1, 0, 5'h0A, 0, "R9 before expiry");
        expect_at(s + 2*U, 1, 5'h05, 0, "R9 full timeout");
        wait_until(s + 2*U + 2);

        // R10: zero count acts as one unit
        put_ctl(8'h05, m);
        put_cnt(8'd0);
        put_ctl(8'h47, m);
        expect_at(m + U - 1, 0, 5'h0A, 0, "R10 before expiry");
        expect_at(m + U, 1, 5'h07, 0, "R10 one unit");
        wait_until(m + U + 3);

        foreach (sb[i]) begin
            n_run++;
            n_fail++;
            $display("FAIL %s: expectation never checked (cycle %0d)", sb[i].tag, sb[i].at);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule